// File: doc/BRIEF.md
# PoE Port Detection Sequencer

This block is the digital control state machine for one power-sourcing Ethernet port. It takes the port through signature detection, then classification, then power-up. Along the way it drives a voltage-setpoint code and a current-limit code to an external analog front end. It reads current samples from an ADC through a valid/data sample interface. From those samples it decides whether the attached device presents a valid signature. It also reports the port state, the agreed class and a detection-fault flag to the host.

Detection forces three voltage points: low, high, then low again. The device is accepted only when the current step is inside the resistance window on the rising edge and also on the falling edge. Classification runs as either one class event or two class events separated by a mark interval. Once the port is powered, it stays on until the load current stays below a hold threshold for a programmable number of samples. After reset the port either starts detecting by itself or waits in shutdown for the host to enable it. A timing-profile select picks the settling and back-off lengths that suit an endpoint or a midspan installation.

Top module: `poe_port_seq`

## Requirements
- R1: A detection cycle drives `vset_code` through 1 (4 V), then 2 (8 V), then 1 (4 V), always in that order. The other setpoint codes are 0 (off), 3 (class), 4 (mark) and 5 (power).
- R2: `ilim_code` is 1 (3 mA) during all three detection points, 2 during class events and the mark interval, 3 while powered, and 0 in shutdown and back-off.
- R3: Each detection point lasts SETTLE+1 clock cycles when `adc_valid` is held high. The current is latched only on the first valid sample after SETTLE cycles. SETTLE is SETTLE_A when `cfg_alt_b`=0 and SETTLE_B when `cfg_alt_b`=1.
- R4: ADC codes are 1 µA per LSB. The signature passes only if both (high − first low) and (high − second low) lie in [DI_MIN, DI_MAX] = [151, 210]. This is 4 V across 26.5 kΩ to 19 kΩ. A failure sets `status_det_fault` and a pass clears it.
- R5: `port_power` rises only directly from a class event. This means detection and classification must both have succeeded first.
- R6: A class sample maps to a class code as follows: below 5000 µA gives 0, below 13000 gives 1, below 21000 gives 2, below 31000 gives 3, and below 45000 gives 4. Any current at or above 45000 is invalid (7) and sends the port to back-off.
- R7: When `cfg_two_event`=1, the first class event is followed by a mark interval (state 6), then a second class event (state 7). If the two codes differ, the port goes to back-off. When `cfg_two_event`=0, the port powers up straight after one event.
- R8: After reset the port is in shutdown. If `cfg_auto_start`=1, it enters detection unprompted a few cycles after reset release. If `cfg_auto_start`=0, it stays in shutdown until `host_en`.
- R9: `host_disable` moves the port to shutdown with all outputs off on the next clock edge, from any state. The port stays there until `host_en`.
- R10: A failed detection or classification leads to back-off. Back-off lasts BACKOFF_A+1 cycles (or BACKOFF_B+1 cycles with `cfg_alt_b`=1), after which detection restarts.
- R11: While powered, the port goes to back-off on the N-th consecutive sample below 7500 µA, where N=`cfg_disc_time` and 0 is treated as 1. A sample at or above the threshold restarts the count.
- R12: `status_state` encodes the states as 0 shutdown, 1 back-off, 2/3/4 the detection points, 5 class 1, 6 mark, 7 class 2 and 8 powered. `status_class` is 0 after reset and is loaded with the agreed class on each power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_start | input | 1 | 1: detect unprompted after reset |
| cfg_alt_b | input | 1 | 1: midspan timing profile |
| cfg_two_event | input | 1 | 1: two-event classification |
| cfg_disc_time | input | DISC_W | Disconnect sample count |
| host_en | input | 1 | Leave shutdown and start detection |
| host_disable | input | 1 | Force shutdown |
| adc_valid | input | 1 | Current sample valid |
| adc_data | input | ADC_W | Current sample, 1 µA per LSB |
| vset_code | output | 3 | Voltage setpoint code to front end |
| ilim_code | output | 2 | Current-limit code to front end |
| port_power | output | 1 | Port is powered |
| status_state | output | 4 | Current state code |
| status_class | output | 3 | Last agreed class code |
| status_det_fault | output | 1 | Last detection failed |

## Verification
The bench places the current step exactly on both edges of the window and just outside them. It does this separately for the rising step and the falling step. A design that checked a single two-point slope, or that used the wrong comparison at an edge, would accept a bad load or reject a good one. The bench counts dwell cycles under both timing profiles. An off-by-one settle or back-off counter, or an ignored profile select, shows up as a wrong count.

The two-event runs use classes that agree and classes that differ. A design that skipped the comparison would power a disagreeing device. The disconnect run breaks a below-threshold streak one sample short of the limit. A design that failed to restart the count would then drop power too early. Host disable is applied in the middle of detection and while powered, to catch a state that ignores it.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_BACKOFF = 4'd1,
    ST_DET_A   = 4'd2,
    ST_DET_B   = 4'd3,
    ST_DET_C   = 4'd4,
    ST_CLS_1   = 4'd5,
    ST_MARK    = 4'd6,
    ST_CLS_2   = 4'd7,
    ST_POWER   = 4'd8
  } port_state_e;

  localparam logic [2:0] VS_OFF   = 3'd0;
  localparam logic [2:0] VS_LOW   = 3'd1;
  localparam logic [2:0] VS_HIGH  = 3'd2;
  localparam logic [2:0] VS_CLASS = 3'd3;
  localparam logic [2:0] VS_MARK  = 3'd4;
  localparam logic [2:0] VS_POWER = 3'd5;

  localparam logic [1:0] IL_OFF   = 2'd0;
  localparam logic [1:0] IL_DET   = 2'd1;
  localparam logic [1:0] IL_CLASS = 2'd2;
  localparam logic [1:0] IL_POWER = 2'd3;

  localparam int unsigned CLS_BANDS = 5;
  // Upper edges of class bands in microamps; index 0 is the lowest band.
  localparam logic [CLS_BANDS-1:0][31:0] CLS_EDGE =
    {32'd45000, 32'd31000, 32'd21000, 32'd13000, 32'd5000};
  localparam logic [2:0] CLS_BAD = 3'd7;

endpackage

// File: rtl/poe_interval_tmr.sv
module poe_interval_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/poe_sig_judge.sv
module poe_sig_judge #(
  parameter int ADC_W  = 16,
  parameter int DI_MIN = 151,
  parameter int DI_MAX = 210
) (
  input  logic [ADC_W-1:0] i_low1,
  input  logic [ADC_W-1:0] i_high,
  input  logic [ADC_W-1:0] i_low2,
  output logic             rise_ok,
  output logic             fall_ok
);

  localparam int DW = ADC_W + 1;

  logic [1:0][ADC_W-1:0] low_pt;
  logic [1:0]            step_ok;

  assign low_pt = {i_low2, i_low1};

  // One window check per step: index 0 rising, index 1 falling.
  for (genvar g = 0; g < 2; g++) begin : g_step
    logic signed [DW-1:0] delta;
    assign delta = $signed({1'b0, i_high}) - $signed({1'b0, low_pt[g]});
    assign step_ok[g] = (delta >= $signed(DW'(DI_MIN))) &&
                        (delta <= $signed(DW'(DI_MAX)));
  end

  assign rise_ok = step_ok[0];
  assign fall_ok = step_ok[1];

endmodule

// File: rtl/poe_cls_map.sv
module poe_cls_map
  import poe_seq_pkg::*;
#(
  parameter int ADC_W = 16
) (
  input  logic [ADC_W-1:0] cur,
  output logic [2:0]       cls
);

  logic [2:0] band;

  always_comb begin
    band = 3'd0;
    for (int k = 0; k < CLS_BANDS; k++) begin
      if (32'(cur) >= CLS_EDGE[k]) band = band + 3'd1;
    end
    cls = (band == 3'(CLS_BANDS)) ? CLS_BAD : band;
  end

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
  import poe_seq_pkg::*;
#(
  parameter int ADC_W     = 16,
  parameter int DISC_W    = 8,
  parameter int TMR_W     = 16,
  parameter int SETTLE_A  = 8,
  parameter int SETTLE_B  = 12,
  parameter int BACKOFF_A = 20,
  parameter int BACKOFF_B = 40,
  parameter int CLASS_T   = 6,
  parameter int MARK_T    = 4,
  parameter int DI_MIN    = 151,
  parameter int DI_MAX    = 210,
  parameter int HOLD_TH   = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_start,
  input  logic              cfg_alt_b,
  input  logic              cfg_two_event,
  input  logic [DISC_W-1:0] cfg_disc_time,
  input  logic              host_en,
  input  logic              host_disable,
  input  logic              adc_valid,
  input  logic [ADC_W-1:0]  adc_data,
  output logic [2:0]        vset_code,
  output logic [1:0]        ilim_code,
  output logic              port_power,
  output logic [3:0]        status_state,
  output logic [2:0]        status_class,
  output logic              status_det_fault
);

  localparam logic [TMR_W-1:0] SET_A_T  = TMR_W'(SETTLE_A);
  localparam logic [TMR_W-1:0] SET_B_T  = TMR_W'(SETTLE_B);
  localparam logic [TMR_W-1:0] BOFF_A_T = TMR_W'(BACKOFF_A);
  localparam logic [TMR_W-1:0] BOFF_B_T = TMR_W'(BACKOFF_B);
  localparam logic [TMR_W-1:0] CLS_T    = TMR_W'(CLASS_T);
  localparam logic [TMR_W-1:0] MRK_T    = TMR_W'(MARK_T);
  localparam logic [ADC_W-1:0] HOLD_LVL = ADC_W'(HOLD_TH);

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  port_state_e      st_q, st_d;
  logic             boot_q;
  logic [ADC_W-1:0] i_low1_q, i_high_q;
  logic [2:0]       cls1_q, cls_out_q;
  logic             flt_q, flt_d;
  logic             low1_en, high_en, cls1_en, cls_out_en, flt_en;
  logic [2:0]       cls_live;
  logic             rise_ok, fall_ok;
  logic             smp, below;
  logic             tmr_ld, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val, tmr_cnt;
  logic [TMR_W-1:0] settle_t, backoff_t, disc_t;

  assign settle_t  = cfg_alt_b ? SET_B_T  : SET_A_T;
  assign backoff_t = cfg_alt_b ? BOFF_B_T : BOFF_A_T;
  assign disc_t    = (cfg_disc_time == '0) ? TMR_W'(1) : TMR_W'(cfg_disc_time);
  assign smp       = adc_valid && tmr_zero;
  assign below     = adc_data < HOLD_LVL;

  poe_interval_tmr #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  poe_sig_judge #(.ADC_W(ADC_W), .DI_MIN(DI_MIN), .DI_MAX(DI_MAX)) u_judge (
    .i_low1  (i_low1_q),
    .i_high  (i_high_q),
    .i_low2  (adc_data),
    .rise_ok (rise_ok),
    .fall_ok (fall_ok)
  );

  poe_cls_map #(.ADC_W(ADC_W)) u_cls (
    .cur (adc_data),
    .cls (cls_live)
  );

  function automatic logic [TMR_W-1:0] entry_time(
    input port_state_e s, input logic [TMR_W-1:0] st_t,
    input logic [TMR_W-1:0] bo_t, input logic [TMR_W-1:0] dc_t);
    case (s)
      ST_DET_A, ST_DET_B, ST_DET_C: entry_time = st_t;
      ST_BACKOFF:                   entry_time = bo_t;
      ST_CLS_1, ST_CLS_2:           entry_time = CLS_T;
      ST_MARK:                      entry_time = MRK_T;
      ST_POWER:                     entry_time = dc_t;
      default:                      entry_time = '0;
    endcase
  endfunction

  // Next-state and control.
  always_comb begin
    st_d       = st_q;
    tmr_ld     = 1'b0;
    tmr_val    = '0;
    tmr_dec    = 1'b0;
    low1_en    = 1'b0;
    high_en    = 1'b0;
    cls1_en    = 1'b0;
    cls_out_en = 1'b0;
    flt_en     = 1'b0;
    flt_d      = flt_q;
    unique case (st_q)
      ST_OFF: begin
        if (host_en || (boot_q && cfg_auto_start)) st_d = ST_DET_A;
      end
      ST_BACKOFF: begin
        if (tmr_zero) st_d = ST_DET_A;
      end
      ST_DET_A: begin
        if (smp) begin
          low1_en = 1'b1;
          st_d    = ST_DET_B;
        end
      end
      ST_DET_B: begin
        if (smp) begin
          high_en = 1'b1;
          st_d    = ST_DET_C;
        end
      end
      ST_DET_C: begin
        if (smp) begin
          flt_en = 1'b1;
          if (rise_ok && fall_ok) begin
            flt_d = 1'b0;
            st_d  = ST_CLS_1;
          end else begin
            flt_d = 1'b1;
            st_d  = ST_BACKOFF;
          end
        end
      end
      ST_CLS_1: begin
        if (smp) begin
          if (cls_live == CLS_BAD) begin
            st_d = ST_BACKOFF;
          end else if (!cfg_two_event) begin
            cls_out_en = 1'b1;
            st_d       = ST_POWER;
          end else begin
            cls1_en = 1'b1;
            st_d    = ST_MARK;
          end
        end
      end
      ST_MARK: begin
        if (tmr_zero) st_d = ST_CLS_2;
      end
      ST_CLS_2: begin
        if (smp) begin
          if (cls_live == cls1_q) begin
            cls_out_en = 1'b1;
            st_d       = ST_POWER;
          end else begin
            st_d = ST_BACKOFF;
          end
        end
      end
      ST_POWER: begin
        if (adc_valid) begin
          if (below) begin
            if (tmr_cnt <= TMR_W'(1)) st_d = ST_BACKOFF;
            else                      tmr_dec = 1'b1;
          end else begin
            tmr_ld  = 1'b1;
            tmr_val = disc_t;
          end
        end
      end
      default: st_d = ST_OFF;
    endcase

    if (host_disable) st_d = ST_OFF;

    if (st_d != st_q) begin
      tmr_ld  = 1'b1;
      tmr_dec = 1'b0;
      tmr_val = entry_time(st_d, settle_t, backoff_t, disc_t);
    end else if (st_q != ST_POWER) begin
      tmr_dec = 1'b1;
    end
  end

  // State and captured data.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q      <= ST_OFF;
      boot_q    <= 1'b1;
      i_low1_q  <= '0;
      i_high_q  <= '0;
      cls1_q    <= '0;
      cls_out_q <= '0;
      flt_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      boot_q <= 1'b0;
      if (low1_en)    i_low1_q  <= adc_data;
      if (high_en)    i_high_q  <= adc_data;
      if (cls1_en)    cls1_q    <= cls_live;
      if (cls_out_en) cls_out_q <= cls_live;
      if (flt_en)     flt_q     <= flt_d;
    end
  end

  // Front-end drive codes.
  always_comb begin
    vset_code = VS_OFF;
    ilim_code = IL_OFF;
    case (st_q)
      ST_DET_A, ST_DET_C: begin vset_code = VS_LOW;   ilim_code = IL_DET;   end
      ST_DET_B:           begin vset_code = VS_HIGH;  ilim_code = IL_DET;   end
      ST_CLS_1, ST_CLS_2: begin vset_code = VS_CLASS; ilim_code = IL_CLASS; end
      ST_MARK:            begin vset_code = VS_MARK;  ilim_code = IL_CLASS; end
      ST_POWER:           begin vset_code = VS_POWER; ilim_code = IL_POWER; end
      default:            begin vset_code = VS_OFF;   ilim_code = IL_OFF;   end
    endcase
  end

  assign port_power       = (st_q == ST_POWER);
  assign status_state     = st_q;
  assign status_class     = cls_out_q;
  assign status_det_fault = flt_q;

endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk
  import poe_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_two_event,
  input logic       host_disable,
  input logic [2:0] vset_code,
  input logic [1:0] ilim_code,
  input logic       port_power,
  input logic [3:0] status_state,
  input logic [2:0] status_class,
  input logic       status_det_fault
);

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_DET_B) |-> ($past(status_state) == ST_DET_A || $past(status_state) == ST_DET_B)) // R1
    else $error("high point not preceded by first low point");

  AST_LOW2_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_DET_C) |-> ($past(status_state) == ST_DET_B || $past(status_state) == ST_DET_C)) // R1
    else $error("second low point not preceded by high point");

  AST_POWER_AFTER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_power) |-> ($past(status_state) == ST_CLS_1 || $past(status_state) == ST_CLS_2)) // R5
    else $error("power applied without a class event");

  AST_CLASS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_CLS_1) |-> !status_det_fault) // R4
    else $error("classification entered with detection fault");

  AST_MARK_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_state == ST_MARK && $past(status_state) == ST_CLS_1) |-> $past(cfg_two_event)) // R7
    else $error("mark interval in one-event mode");

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    host_disable |=> (status_state == ST_OFF && vset_code == VS_OFF && ilim_code == IL_OFF)) // R9
    else $error("host disable did not shut the port down");

  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (port_power && $past(port_power)) |-> $stable(status_class)) // R12
    else $error("class report changed while powered");

endmodule

bind poe_port_seq poe_port_seq_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_two_event    (cfg_two_event),
  .host_disable     (host_disable),
  .vset_code        (vset_code),
  .ilim_code        (ilim_code),
  .port_power       (port_power),
  .status_state     (status_state),
  .status_class     (status_class),
  .status_det_fault (status_det_fault)
);

// File: tb/poe_port_seq_bench.sv
module poe_port_seq_bench;

  localparam int SET_A = 8;
  localparam int SET_B = 12;
  localparam int BO_A  = 20;
  localparam int BO_B  = 40;

  logic        clk;
  logic        rst_n;
  logic        cfg_auto_start;
  logic        cfg_alt_b;
  logic        cfg_two_event;
  logic [7:0]  cfg_disc_time;
  logic        host_en;
  logic        host_disable;
  logic        adc_valid;
  logic [15:0] adc_data;
  logic [2:0]  vset_code;
  logic [1:0]  ilim_code;
  logic        port_power;
  logic [3:0]  status_state;
  logic [2:0]  status_class;
  logic        status_det_fault;

  logic [15:0] m_low1, m_high, m_low2, m_cls1, m_cls2, m_pwr;
  int n_chk;
  int n_fail;
  bit done;

  poe_port_seq #(
    .ADC_W(16), .DISC_W(8), .TMR_W(16), .SETTLE_A(SET_A), .SETTLE_B(SET_B),
    .BACKOFF_A(BO_A), .BACKOFF_B(BO_B), .CLASS_T(6), .MARK_T(4),
    .DI_MIN(151), .DI_MAX(210), .HOLD_TH(7500)
  ) u_poe_port_seq (
    .clk(clk), .rst_n(rst_n), .cfg_auto_start(cfg_auto_start),
    .cfg_alt_b(cfg_alt_b), .cfg_two_event(cfg_two_event),
    .cfg_disc_time(cfg_disc_time), .host_en(host_en),
    .host_disable(host_disable), .adc_valid(adc_valid), .adc_data(adc_data),
    .vset_code(vset_code), .ilim_code(ilim_code), .port_power(port_power),
    .status_state(status_state), .status_class(status_class),
    .status_det_fault(status_det_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Load model: current returned for each forced point.
  always_comb begin
    case (status_state)
      4'd2:    adc_data = m_low1;
      4'd3:    adc_data = m_high;
      4'd4:    adc_data = m_low2;
      4'd5:    adc_data = m_cls1;
      4'd7:    adc_data = m_cls2;
      4'd8:    adc_data = m_pwr;
      default: adc_data = 16'd0;
    endcase
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_state(input logic [3:0] st, input string req);
    int k = 0;
    while (status_state != st && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk_eq(req, "reach state", status_state, st);
  endtask

  task automatic dwell(input logic [3:0] st, output int n);
    n = 0;
    while (status_state == st && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_model(input int lo1, input int hi, input int lo2, input int c1, input int c2);
    m_low1 = 16'(lo1); m_high = 16'(hi); m_low2 = 16'(lo2);
    m_cls1 = 16'(c1);  m_cls2 = 16'(c2);
  endtask

  // Shutdown, then enable: leaves the port at the first low point.
  task automatic restart();
    @(negedge clk); host_disable = 1'b1;
    @(negedge clk); host_disable = 1'b0; host_en = 1'b1;
    @(negedge clk); host_en = 1'b0;
  endtask

  task automatic do_reset(input bit auto_mode);
    cfg_auto_start = auto_mode;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0);
    @(negedge clk);
    chk_eq("R12", "reset state", status_state, 0);
    chk_eq("R2", "reset ilim", ilim_code, 0);
    chk_eq("R1", "reset vset", vset_code, 0);
    chk_eq("R12", "reset class", status_class, 0);
    chk_eq("R4", "reset fault", status_det_fault, 0);
    repeat (20) @(negedge clk);
    chk_eq("R8", "shutdown mode waits", status_state, 0);
  endtask

  task automatic t_auto_start();
    do_reset(1'b1);
    repeat (4) @(negedge clk);
    chk_eq("R8", "auto mode detects", status_state, 2);
    do_reset(1'b0);
  endtask

  task automatic t_one_event();
    int n;
    cfg_two_event = 1'b0; cfg_alt_b = 1'b0;
    set_model(100, 280, 100, 10000, 10000);
    restart();
    chk_eq("R1", "first point vset", vset_code, 1);
    chk_eq("R2", "first point ilim", ilim_code, 1);
    dwell(4'd2, n);
    chk_eq("R3", "settle dwell A", n, SET_A + 1);
    chk_eq("R1", "second point state", status_state, 3);
    chk_eq("R1", "second point vset", vset_code, 2);
    chk_eq("R2", "second point ilim", ilim_code, 1);
    dwell(4'd3, n);
    chk_eq("R1", "third point vset", vset_code, 1);
    chk_eq("R2", "third point ilim", ilim_code, 1);
    dwell(4'd4, n);
    chk_eq("R5", "class after detect", status_state, 5);
    chk_eq("R2", "class ilim", ilim_code, 2);
    dwell(4'd5, n);
    chk_eq("R7", "one event powers", status_state, 8);
    chk_eq("R5", "port power", port_power, 1);
    chk_eq("R2", "power ilim", ilim_code, 3);
    chk_eq("R12", "class reported", status_class, 1);
    chk_eq("R4", "fault clear", status_det_fault, 0);
  endtask

  task automatic t_disconnect();
    m_pwr = 16'd5000;
    repeat (5) @(negedge clk);
    chk_eq("R11", "five low samples keep power", status_state, 8);
    m_pwr = 16'd7500;
    @(negedge clk);
    m_pwr = 16'd5000;
    repeat (5) @(negedge clk);
    chk_eq("R11", "count restarted", status_state, 8);
    @(negedge clk);
    chk_eq("R11", "sixth low sample drops", status_state, 1);
    chk_eq("R11", "power off", port_power, 0);
    m_pwr = 16'd20000;
  endtask

  task automatic run_det(input int lo1, input int hi, input int lo2, input bit pass, input string tag);
    set_model(lo1, hi, lo2, 10000, 10000);
    restart();
    wait_state(4'd4, "R4");
    while (status_state == 4'd4) @(negedge clk);
    chk_eq("R4", {tag, " outcome"}, status_state, pass ? 5 : 1);
    chk_eq("R4", {tag, " fault"}, status_det_fault, pass ? 0 : 1);
  endtask

  task automatic t_sig_bounds();
    run_det(100, 251, 100, 1'b1, "step 151");
    run_det(100, 250, 100, 1'b0, "step 150");
    run_det(100, 310, 100, 1'b1, "step 210");
    run_det(100, 311, 100, 1'b0, "step 211");
    run_det(100, 280, 150, 1'b0, "falling step short");
    run_det(150, 280, 100, 1'b0, "rising step short");
    run_det(300, 100, 300, 1'b0, "negative steps");
  endtask

  task automatic t_alt_b();
    int n;
    cfg_alt_b = 1'b1;
    set_model(100, 200, 100, 10000, 10000);
    restart();
    dwell(4'd2, n);
    chk_eq("R3", "settle dwell B", n, SET_B + 1);
    wait_state(4'd1, "R10");
    dwell(4'd1, n);
    chk_eq("R10", "backoff dwell B", n, BO_B + 1);
    chk_eq("R10", "retry after backoff", status_state, 2);
    cfg_alt_b = 1'b0;
    wait_state(4'd1, "R10");
    dwell(4'd1, n);
    chk_eq("R10", "backoff dwell A", n, BO_A + 1);
  endtask

  task automatic t_two_event();
    int n;
    cfg_two_event = 1'b1;
    set_model(100, 280, 100, 18000, 18000);
    restart();
    wait_state(4'd6, "R7");
    chk_eq("R7", "mark vset", vset_code, 4);
    wait_state(4'd8, "R7");
    chk_eq("R12", "two-event class", status_class, 2);
    set_model(100, 280, 100, 18000, 28000);
    restart();
    wait_state(4'd7, "R7");
    dwell(4'd7, n);
    chk_eq("R7", "mismatch backs off", status_state, 1);
    chk_eq("R7", "no power on mismatch", port_power, 0);
    cfg_two_event = 1'b0;
  endtask

  task automatic power_class(input int cur, input int exp, input string tag);
    set_model(100, 280, 100, cur, cur);
    restart();
    wait_state(4'd8, "R6");
    chk_eq("R6", tag, status_class, exp);
  endtask

  task automatic t_class_map();
    int n;
    power_class(4999, 0, "class 0 at 4999");
    power_class(5000, 1, "class 1 at 5000");
    power_class(30999, 3, "class 3 at 30999");
    power_class(44999, 4, "class 4 at 44999");
    set_model(100, 280, 100, 45000, 45000);
    restart();
    wait_state(4'd5, "R6");
    dwell(4'd5, n);
    chk_eq("R6", "invalid class backs off", status_state, 1);
  endtask

  task automatic t_host_disable();
    set_model(100, 280, 100, 10000, 10000);
    restart();
    wait_state(4'd3, "R9");
    host_disable = 1'b1;
    @(negedge clk);
    host_disable = 1'b0;
    chk_eq("R9", "disable mid detection", status_state, 0);
    chk_eq("R9", "vset off", vset_code, 0);
    repeat (15) @(negedge clk);
    chk_eq("R9", "stays shut down", status_state, 0);
    restart();
    wait_state(4'd8, "R9");
    host_disable = 1'b1;
    @(negedge clk);
    host_disable = 1'b0;
    chk_eq("R9", "disable while powered", port_power, 0);
    chk_eq("R9", "ilim off", ilim_code, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_auto_start = 1'b0; cfg_alt_b = 1'b0;
    cfg_two_event = 1'b0; cfg_disc_time = 8'd6;
    host_en = 1'b0; host_disable = 1'b0; adc_valid = 1'b1;
    m_low1 = '0; m_high = '0; m_low2 = '0; m_cls1 = '0; m_cls2 = '0;
    m_pwr = 16'd20000;
    t_reset_state();
    t_auto_start();
    t_one_event();
    t_disconnect();
    t_sig_bounds();
    t_alt_b();
    t_two_event();
    t_class_map();
    t_host_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule